// File: doc/BRIEF.md
# Bus Hold Grant Controller

This block sits on the processor side of a shared address, data and control bus. It lets an external master, such as a DMA engine or a second processor, take that bus over. When the external request arrives, the block does not start any new local bus cycle. It lets the cycle already in progress run to its end, then turns off its own address, data and control drivers. Only after that does it raise a hold acknowledge.

The acknowledge stays high for as long as the requester keeps its request asserted. When the request goes away, the block first lowers the acknowledge. After a settling gap it turns its drivers back on, and after a short reclaim interval it lets the local cycle generator start cycles again.

The local cycle generator is modelled by two signals. It reports a cycle in progress on a busy line. It may only begin a new cycle while the block's start-permission output is high. The acknowledge is also brought out as an active-low output enable for an external address latch and data buffers, so those parts float while the bus is held.

Top module: `bus_yield_ctrl`

## Requirements
- R1: The acknowledge `hold_ack_o` rises only after `hold_req_i` has been high. With the local bus idle, it rises SYNC_STAGES+2+FLOAT_CYCLES rising clock edges after the request is first sampled high.
- R2: While `cyc_busy_i` is high, all three driver enables stay high and the acknowledge stays low. The drivers turn off at edge max(SYNC_STAGES+2, B+1) after the request, where B is the number of edges for which busy stays high after the request.
- R3: All three driver enables (`addr_oe_o`, `data_oe_o`, `ctrl_oe_o`, 1 = driving) are low for exactly FLOAT_CYCLES clocks before the acknowledge rises.
- R4: The acknowledge stays high for as long as the request stays high, and it falls SYNC_STAGES+1 edges after the request falls. While the acknowledge is high, all three driver enables are low.
- R5: The driver enables come back high RELEASE_CYCLES edges after the acknowledge falls. They are never high while the acknowledge is high.
- R6: `ext_buf_oe_n_o` is an active-low enable for an external latch and data buffers. It is equal to `hold_ack_o` at all times: 1 means floated.
- R7: `cyc_start_ok_o` goes low SYNC_STAGES edges after the request rises and stays low in every state other than idle. It returns high RECLAIM_CYCLES edges after the driver enables come back.
- R8: If the request is withdrawn while the block is still waiting for a local cycle to end, the block returns to idle. The drivers are never turned off and the acknowledge is never raised.
- R9: A synchronous active-high reset puts the block in idle: driver enables high, acknowledge low, start permission high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_i | input | 1 | Bus request from the external master, asynchronous |
| cyc_busy_i | input | 1 | A local bus cycle is in progress |
| cyc_start_ok_o | output | 1 | The local cycle generator may start a new cycle |
| addr_oe_o | output | 1 | Address driver enable, 1 = driving |
| data_oe_o | output | 1 | Data driver enable, 1 = driving |
| ctrl_oe_o | output | 1 | Control driver enable, 1 = driving |
| hold_ack_o | output | 1 | Hold acknowledge to the external master |
| ext_buf_oe_n_o | output | 1 | Active-low enable for the external latch and buffers |

## Verification
The bench builds the block with SYNC_STAGES=2, FLOAT_CYCLES=2, RELEASE_CYCLES=3 and RECLAIM_CYCLES=2. With these values every dwell state is longer than one clock, so an off-by-one in any dwell counter moves a measured edge. The bench sweeps the busy length from 0 to 5 against hold lengths from 1 to 3. This reaches both sides of the max() in R2: at short busy lengths the synchronizer sets the latency, and at long ones the busy cycle does. Separate runs cover a request withdrawn during the wait state and a reset applied in the middle of a grant.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_END = 3'd1,
        ST_FLOAT    = 3'd2,
        ST_GRANTED  = 3'd3,
        ST_RELEASE  = 3'd4,
        ST_RECLAIM  = 3'd5
    } yield_state_e;

    // One enable per bus group; 1 = local drivers active
    typedef struct packed {
        logic addr;
        logic data;
        logic ctrl;
    } bus_oe_t;

    localparam int NUM_BUS = $bits(bus_oe_t);

    // States in which the local side owns and drives the bus
    function automatic logic state_drives(yield_state_e s);
        return (s == ST_IDLE) || (s == ST_WAIT_END) || (s == ST_RECLAIM);
    endfunction

    function automatic bus_oe_t oe_for_state(yield_state_e s);
        bus_oe_t o;
        o.addr = state_drives(s);
        o.data = state_drives(s);
        o.ctrl = state_drives(s);
        return o;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/yield_req_sync.sv
module yield_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= STAGES'({chain_q, async_i});
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/yield_dwell_timer.sv
module yield_dwell_timer #(
    parameter int MAX_LEN = 1,
    localparam int W = $clog2(MAX_LEN + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i)   count_q <= '0;
        else if (count_q != '1) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;
endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
    import bus_yield_pkg::*;
#(
    parameter int FLOAT_CYCLES   = 1,
    parameter int RELEASE_CYCLES = 1,
    parameter int RECLAIM_CYCLES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_s_i,
    input  logic         busy_i,
    output yield_state_e state_q_o,
    output yield_state_e state_d_o
);
    localparam int MAX_LEN = max3(FLOAT_CYCLES, RELEASE_CYCLES, RECLAIM_CYCLES);
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] FLOAT_LAST   = CW'(FLOAT_CYCLES - 1);
    localparam logic [CW-1:0] RELEASE_LAST = CW'(RELEASE_CYCLES - 1);
    localparam logic [CW-1:0] RECLAIM_LAST = CW'(RECLAIM_CYCLES - 1);

    yield_state_e  state_q, state_d;
    logic [CW-1:0] dwell;

    yield_dwell_timer #(.MAX_LEN(MAX_LEN)) i_dwell (
        .clk      (clk),
        .rst      (rst),
        .restart_i(state_d != state_q),
        .count_o  (dwell)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_s_i) state_d = ST_WAIT_END;
            ST_WAIT_END: begin
                if (!req_s_i)     state_d = ST_IDLE;
                else if (!busy_i) state_d = ST_FLOAT;
            end
            ST_FLOAT: begin
                if (!req_s_i)                 state_d = ST_RECLAIM;
                else if (dwell == FLOAT_LAST) state_d = ST_GRANTED;
            end
            ST_GRANTED:  if (!req_s_i) state_d = ST_RELEASE;
            ST_RELEASE:  if (dwell == RELEASE_LAST) state_d = ST_RECLAIM;
            ST_RECLAIM:  if (dwell == RECLAIM_LAST) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_q_o = state_q;
    assign state_d_o = state_d;
endmodule

// File: rtl/yield_bus_drive.sv
module yield_bus_drive
    import bus_yield_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  yield_state_e state_d_i,
    output bus_oe_t      oe_o,
    output logic         ack_o
);
    logic [NUM_BUS-1:0] want;
    logic [NUM_BUS-1:0] oe_q;
    logic               ack_q;

    assign want = oe_for_state(state_d_i);

    // One registered enable per bus group, glitch-free at the pins
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_oe
        always_ff @(posedge clk) begin
            if (rst) oe_q[b] <= 1'b1;
            else     oe_q[b] <= want[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= (state_d_i == ST_GRANTED);
    end

    assign oe_o  = bus_oe_t'(oe_q);
    assign ack_o = ack_q;
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
    import bus_yield_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FLOAT_CYCLES   = 1,
    parameter int RELEASE_CYCLES = 1,
    parameter int RECLAIM_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req_i,
    input  logic cyc_busy_i,
    output logic cyc_start_ok_o,
    output logic addr_oe_o,
    output logic data_oe_o,
    output logic ctrl_oe_o,
    output logic hold_ack_o,
    output logic ext_buf_oe_n_o
);
    logic         req_s;
    yield_state_e state_q, state_d;
    bus_oe_t      oe;
    logic         ack;

    yield_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(hold_req_i),
        .sync_o (req_s)
    );

    yield_fsm #(
        .FLOAT_CYCLES  (FLOAT_CYCLES),
        .RELEASE_CYCLES(RELEASE_CYCLES),
        .RECLAIM_CYCLES(RECLAIM_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_s_i  (req_s),
        .busy_i   (cyc_busy_i),
        .state_q_o(state_q),
        .state_d_o(state_d)
    );

    yield_bus_drive i_drive (
        .clk      (clk),
        .rst      (rst),
        .state_d_i(state_d),
        .oe_o     (oe),
        .ack_o    (ack)
    );

    // New local cycles only from idle and only with no pending request
    assign cyc_start_ok_o = (state_q == ST_IDLE) && !req_s;
    assign addr_oe_o      = oe.addr;
    assign data_oe_o      = oe.data;
    assign ctrl_oe_o      = oe.ctrl;
    assign hold_ack_o     = ack;
    assign ext_buf_oe_n_o = ack;
endmodule

// File: rtl/bus_yield_chk.sv
module bus_yield_chk (
    input logic clk,
    input logic rst,
    input logic cyc_busy_i,
    input logic cyc_start_ok_o,
    input logic addr_oe_o,
    input logic data_oe_o,
    input logic ctrl_oe_o,
    input logic hold_ack_o
);
    // R3: all drivers already off in the cycle before acknowledge rises
    a_r3_float_before_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_o) |-> ($past(!addr_oe_o) && $past(!data_oe_o) && $past(!ctrl_oe_o)));

    // R4: no local driver active while the bus is granted
    a_r4_no_drive_when_granted: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> (!addr_oe_o && !data_oe_o && !ctrl_oe_o));

    // R2: drivers never floated while a local cycle is still running
    a_r2_no_float_mid_cycle: assert property (@(posedge clk) disable iff (rst)
        !addr_oe_o |-> !cyc_busy_i);

    // R5: drivers come back only once acknowledge was already low
    a_r5_reenable_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe_o) |-> ($past(!hold_ack_o) && !hold_ack_o));

    // R7: no cycle starts while floated or granted
    a_r7_no_start_when_yielded: assert property (@(posedge clk) disable iff (rst)
        (!addr_oe_o || hold_ack_o) |-> !cyc_start_ok_o);

    // R9: state right after a reset clock
    a_r9_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (addr_oe_o && data_oe_o && ctrl_oe_o && !hold_ack_o));
endmodule

bind bus_yield_ctrl bus_yield_chk i_chk (.*);

// File: tb/test_bus_yield_ctrl.sv
module test_bus_yield_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int S  = 2;
    localparam int F  = 2;
    localparam int RL = 3;
    localparam int RC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic busy = 1'b0;
    logic start_ok, a_oe, d_oe, c_oe, ack, ext_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_yield_ctrl #(
        .SYNC_STAGES(S), .FLOAT_CYCLES(F), .RELEASE_CYCLES(RL), .RECLAIM_CYCLES(RC)
    ) i_bus_yield_ctrl (
        .clk(clk), .rst(rst), .hold_req_i(req), .cyc_busy_i(busy),
        .cyc_start_ok_o(start_ok), .addr_oe_o(a_oe), .data_oe_o(d_oe),
        .ctrl_oe_o(c_oe), .hold_ack_o(ack), .ext_buf_oe_n_o(ext_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int all_oe();
        return (a_oe && d_oe && c_oe) ? 1 : 0;
    endfunction

    function automatic int any_oe();
        return (a_oe || d_oe || c_oe) ? 1 : 0;
    endfunction

    // One full grant/release round; edge k = k-th rising edge after stimulus
    task automatic grant_round(input int busy_len, input int hold_len);
        int ok_edge = -1, oe_edge = -1, ack_edge = -1;
        int exp_float;
        int fall_edge = -1, back_edge = -1, start_edge = -1;
        @(negedge clk);
        check(start_ok == 1'b1, "R7 idle start permission", start_ok, 1);
        if (busy_len > 0) busy = 1'b1;
        req = 1'b1;
        for (int k = 1; k <= 40 && ack_edge < 0; k++) begin
            @(negedge clk);
            if (!start_ok && ok_edge < 0) ok_edge = k;
            if (!a_oe && oe_edge < 0) oe_edge = k;
            if (ack && ack_edge < 0) ack_edge = k;
            if (busy) check(all_oe() == 1 && !ack, "R2 drivers kept during busy", all_oe(), 1);
            if (ack) check(any_oe() == 0, "R4 floated while granted", any_oe(), 0);
            check(ext_n == ack, "R6 ext enable follows ack", ext_n, ack);
            if (k == busy_len) busy = 1'b0;
        end
        exp_float = (S + 2 > busy_len + 1) ? S + 2 : busy_len + 1;
        check(ok_edge == S, "R7 start blocked after sync", ok_edge, S);
        check(oe_edge == exp_float, "R2 float edge", oe_edge, exp_float);
        check(ack_edge == exp_float + F, "R1 ack edge", ack_edge, exp_float + F);
        check(ack_edge - oe_edge == F, "R3 float lead", ack_edge - oe_edge, F);
        for (int h = 0; h < hold_len; h++) begin
            @(negedge clk);
            check(ack == 1'b1, "R4 ack held with request", ack, 1);
            check(start_ok == 1'b0, "R7 start blocked while granted", start_ok, 0);
        end
        req = 1'b0;
        for (int k = 1; k <= 40 && start_edge < 0; k++) begin
            @(negedge clk);
            if (!ack && fall_edge < 0) fall_edge = k;
            if (a_oe && back_edge < 0) back_edge = k;
            if (start_ok && start_edge < 0) start_edge = k;
            if (any_oe() != 0) check(!ack, "R5 drivers back only with ack low", ack, 0);
            check(ext_n == ack, "R6 ext enable follows ack", ext_n, ack);
        end
        check(fall_edge == S + 1, "R4 ack fall edge", fall_edge, S + 1);
        check(back_edge == S + 1 + RL, "R5 driver return edge", back_edge, S + 1 + RL);
        check(start_edge == S + 1 + RL + RC, "R7 start return edge", start_edge, S + 1 + RL + RC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(all_oe() == 1, "R9 drivers on after reset", all_oe(), 1);
        check(ack == 1'b0, "R9 ack low after reset", ack, 0);
        check(start_ok == 1'b1, "R9 start allowed after reset", start_ok, 1);
        check(ext_n == 1'b0, "R6 ext enable after reset", ext_n, 0);

        // Sweep busy length against hold length (R1..R7)
        for (int b = 0; b <= 5; b++)
            for (int h = 1; h <= 3; h++)
                grant_round(b, h);

        // R8: request withdrawn during the wait for a long local cycle
        @(negedge clk);
        busy = 1'b1;
        req  = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            check(all_oe() == 1, "R8 drivers stay on", all_oe(), 1);
            check(ack == 1'b0, "R8 no ack", ack, 0);
            if (k == 4)  req  = 1'b0;
            if (k == 10) busy = 1'b0;
        end
        check(start_ok == 1'b1, "R8 back to idle", start_ok, 1);

        // R9: reset in the middle of a grant
        req = 1'b1;
        repeat (S + 2 + F + 2) @(negedge clk);
        check(ack == 1'b1, "R1 granted before reset", ack, 1);
        rst = 1'b1;
        req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(all_oe() == 1, "R9 drivers on after mid-grant reset", all_oe(), 1);
        check(ack == 1'b0, "R9 ack low after mid-grant reset", ack, 0);
        check(start_ok == 1'b1, "R9 start allowed after mid-grant reset", start_ok, 1);

        finish_run();
    end
endmodule